// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor that gives each called function a fresh set of working registers without touching memory. Software always addresses 32 registers with a 5-bit number. Eight of them are globals, common to every function. The other 24 come from a window that slides over a larger circular bank of physical storage. Two read ports return data combinationally and one write port updates storage on the rising clock edge. A save input moves the window one step down at a call and a restore input moves it one step up at a return. The number of windows, `NWIN` (legal range 3 to 32), is a parameter. The storage holds 8 globals plus 16 registers per window.

Each window has three groups of eight. Numbers 8 to 15 are the outgoing group, 16 to 23 the local group and 24 to 31 the incoming group. A window's outgoing group is the same storage as the incoming group of the window one step below it, so arguments pass from caller to callee with no copy. Locals belong to one window only. The pointer wraps at both ends of the bank.

A controller counts how many windows are live. It refuses a save that would reuse a window still in use, and raises `ovf_o`. It refuses a restore with no caller window to return to, and raises `unf_o`. The controller is a three-state machine. `ST_BASE` means one window is live. `ST_NEST` means more than one but fewer than `NWIN-1` are live. `ST_FULL` means `NWIN-1` are live. Its transitions are:
- base-to-nest on a save, or base-to-full when `NWIN` is 3.
- nest-to-nest on a save or a restore that stays inside the range.
- nest-to-full on a save that reaches `NWIN-1` live windows.
- full-to-nest and nest-to-base on restores.
- base-hold, with underflow, on a restore in `ST_BASE`.
- full-hold, with overflow, on a save in `ST_FULL`.
- an idle hold when neither input is asserted, or when both are.

Spilling windows to memory and filling them back is left to the surrounding logic.

Top module: `win_regfile`

## Requirements
- R1: Numbers 0 to 7 select eight global registers, and these are the same storage in every window. A global written in one window reads back the same value after a save.
- R2: Register 0 always reads as zero on both ports. A write to register 0 is discarded.
- R3: Numbers 8 to 15 are the outgoing group and 24 to 31 the incoming group. After a save, incoming register 24+k reads what the caller wrote to outgoing register 8+k. After the matching restore, the caller's 8+k reads what the callee wrote to its 24+k.
- R4: Numbers 16 to 23 are locals, private to their window. After a save, a local in the new window does not show the caller's local. After the restore, the caller's local value is back.
- R5: After reset the window pointer `cwp_o` is 0 and one window is live. An accepted save changes the pointer to (cwp-1) mod NWIN. An accepted restore changes it to (cwp+1) mod NWIN. The change takes effect on the clock edge.
- R6: A save requested when NWIN-1 windows are live drives `ovf_o` high in the same cycle. The pointer and the live count do not change.
- R7: A restore requested when only one window is live drives `unf_o` high in the same cycle. The pointer and the live count do not change.
- R8: If save and restore are asserted together, neither takes effect and neither flag rises.
- R9: A read of the physical register that is being written in the same cycle returns the new write data.
- R10: Writes land on the rising clock edge. A write in the same cycle as a save or a restore goes to the window that was current before the move.
- R11: After reset every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| save_i | input | 1 | Move the window down one step (call) |
| restore_i | input | 1 | Move the window up one step (return) |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Architectural write register number |
| wdata_i | input | XLEN | Write data |
| raddr0_i | input | 5 | Read port 0 register number |
| raddr1_i | input | 5 | Read port 1 register number |
| rdata0_o | output | XLEN | Read port 0 data, combinational |
| rdata1_o | output | XLEN | Read port 1 data, combinational |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| ovf_o | output | 1 | Save refused: all usable windows live |
| unf_o | output | 1 | Restore refused: no caller window live |

## Verification
The assertions assume that save and restore are sampled only at clean clock edges. They also assume that a refused save or restore is simply dropped by the surrounding logic, and is not held until the next edge. The stimulus changes every input at the falling edge and keeps each save or restore to a single cycle. Refused requests are issued only on purpose, to make the overflow and underflow flags rise. The live-count assertions also assume that the pointer moves only through the two control inputs. For that reason the stimulus never pulses reset in the middle of a call sequence.

// File: rtl/win_pkg.sv
`timescale 1ns/1ps
package win_pkg;
    typedef enum logic [1:0] {
        ST_BASE = 2'd0,
        ST_NEST = 2'd1,
        ST_FULL = 2'd2
    } depth_st_e;

    localparam int GLOBALS   = 8;
    localparam int GROUP     = 8;
    localparam int PER_WIN   = 16;
    localparam int ARCH_BITS = 5;
endpackage

// File: rtl/win_map.sv
`timescale 1ns/1ps
module win_map
    import win_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN),
    parameter int PW   = $clog2(GLOBALS + PER_WIN * NWIN)
) (
    input  logic [ARCH_BITS-1:0] arch_i,
    input  logic [CW-1:0]        cwp_i,
    output logic [PW-1:0]        phys_o
);
    localparam logic [CW-1:0] LAST_W = CW'(NWIN - 1);

    logic [CW-1:0] below_w;
    int            base_cur;
    int            base_below;
    int            offs;

    always_comb begin
        below_w    = (cwp_i == '0) ? LAST_W : cwp_i - 1'b1;
        base_cur   = GLOBALS + PER_WIN * int'(cwp_i);
        base_below = GLOBALS + PER_WIN * int'(below_w);
        offs       = int'(arch_i[2:0]);
        unique case (arch_i[4:3])
            2'b00:   phys_o = PW'(offs);
            2'b01:   phys_o = PW'(base_below + offs);
            2'b10:   phys_o = PW'(base_cur + GROUP + offs);
            default: phys_o = PW'(base_cur + offs);
        endcase
    end
endmodule

// File: rtl/win_ctrl.sv
`timescale 1ns/1ps
module win_ctrl
    import win_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          save_i,
    input  logic          restore_i,
    output logic [CW-1:0] cwp_o,
    output logic          ovf_o,
    output logic          unf_o
);
    localparam logic [CW-1:0] LAST_W   = CW'(NWIN - 1);
    localparam logic [CW-1:0] MAX_LIVE = CW'(NWIN - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    depth_st_e     st_q, st_d;
    logic [CW-1:0] cwp_q, cwp_d, live_q, live_d;
    logic [CW-1:0] cwp_dn, cwp_up;
    logic          only_save, only_rest;

    assign only_save = save_i & ~restore_i;
    assign only_rest = restore_i & ~save_i;
    assign cwp_dn    = (cwp_q == '0) ? LAST_W : cwp_q - 1'b1;
    assign cwp_up    = (cwp_q == LAST_W) ? '0 : cwp_q + 1'b1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q   <= ST_BASE;
            cwp_q  <= '0;
            live_q <= ONE;
        end else begin
            st_q   <= st_d;
            cwp_q  <= cwp_d;
            live_q <= live_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cwp_d  = cwp_q;
        live_d = live_q;
        ovf_o  = 1'b0;
        unf_o  = 1'b0;
        unique case (st_q)
            ST_BASE: begin
                if (only_save) begin
                    cwp_d  = cwp_dn;
                    live_d = live_q + 1'b1;
                    st_d   = (live_q + 1'b1 == MAX_LIVE) ? ST_FULL : ST_NEST;
                end else if (only_rest) begin
                    unf_o = 1'b1;
                end
            end
            ST_NEST: begin
                if (only_save) begin
                    cwp_d  = cwp_dn;
                    live_d = live_q + 1'b1;
                    st_d   = (live_q + 1'b1 == MAX_LIVE) ? ST_FULL : ST_NEST;
                end else if (only_rest) begin
                    cwp_d  = cwp_up;
                    live_d = live_q - 1'b1;
                    st_d   = (live_q - 1'b1 == ONE) ? ST_BASE : ST_NEST;
                end
            end
            ST_FULL: begin
                if (only_save) begin
                    ovf_o = 1'b1;
                end else if (only_rest) begin
                    cwp_d  = cwp_up;
                    live_d = live_q - 1'b1;
                    st_d   = (live_q - 1'b1 == ONE) ? ST_BASE : ST_NEST;
                end
            end
            default: st_d = ST_BASE;
        endcase
    end

    assign cwp_o = cwp_q;

    // R6: a refused save leaves the pointer where it was
    a_r6_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> $stable(cwp_o));
    // R7: a refused restore leaves the pointer where it was
    a_r7_unf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unf_o |=> $stable(cwp_o));
    // R8: simultaneous requests cancel
    a_r8_both_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (save_i && restore_i) |=> $stable(cwp_o));
    a_r8_both_noflag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (save_i && restore_i) |-> !(ovf_o || unf_o));
    // R5: an accepted save steps the pointer down with wrap
    a_r5_save_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (only_save && !ovf_o) |=>
        (cwp_o == (($past(cwp_o) == '0) ? LAST_W : $past(cwp_o) - 1'b1)));
    // R5: an accepted restore steps the pointer up with wrap
    a_r5_rest_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (only_rest && !unf_o) |=>
        (cwp_o == (($past(cwp_o) == LAST_W) ? '0 : $past(cwp_o) + 1'b1)));
    // R6/R7: the live count stays in range, and the state agrees with it
    a_r6_live_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_q >= ONE) && (live_q <= MAX_LIVE));
    a_r7_base_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_BASE) |-> (live_q == ONE));
endmodule

// File: rtl/win_bank.sv
`timescale 1ns/1ps
module win_bank #(
    parameter int XLEN = 32,
    parameter int PHYS = 136,
    parameter int PW   = $clog2(PHYS)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            we_i,
    input  logic [PW-1:0]   wa_i,
    input  logic [XLEN-1:0] wd_i,
    input  logic [PW-1:0]   ra0_i,
    input  logic [PW-1:0]   ra1_i,
    output logic [XLEN-1:0] rd0_o,
    output logic [XLEN-1:0] rd1_o
);
    logic [XLEN-1:0] mem [PHYS];
    logic            wr_live;

    assign wr_live = we_i && (wa_i != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < PHYS; i++) mem[i] <= '0;
        end else if (wr_live) begin
            mem[wa_i] <= wd_i;
        end
    end

    always_comb begin
        if (ra0_i == '0)                    rd0_o = '0;
        else if (wr_live && wa_i == ra0_i)  rd0_o = wd_i;
        else                                rd0_o = mem[ra0_i];
        if (ra1_i == '0)                    rd1_o = '0;
        else if (wr_live && wa_i == ra1_i)  rd1_o = wd_i;
        else                                rd1_o = mem[ra1_i];
    end

    // R10: an accepted write is in storage after the edge
    a_r10_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_live |=> (mem[$past(wa_i)] == $past(wd_i)));
endmodule

// File: rtl/win_regfile.sv
`timescale 1ns/1ps
module win_regfile
    import win_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NWIN = 8,
    localparam int CW   = $clog2(NWIN),
    localparam int PHYS = GLOBALS + PER_WIN * NWIN,
    localparam int PW   = $clog2(PHYS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 save_i,
    input  logic                 restore_i,
    input  logic                 we_i,
    input  logic [ARCH_BITS-1:0] waddr_i,
    input  logic [XLEN-1:0]      wdata_i,
    input  logic [ARCH_BITS-1:0] raddr0_i,
    input  logic [ARCH_BITS-1:0] raddr1_i,
    output logic [XLEN-1:0]      rdata0_o,
    output logic [XLEN-1:0]      rdata1_o,
    output logic [CW-1:0]        cwp_o,
    output logic                 ovf_o,
    output logic                 unf_o
);
    logic [CW-1:0]        cwp;
    logic [ARCH_BITS-1:0] arch [3];
    logic [PW-1:0]        phys [3];

    assign arch[0] = waddr_i;
    assign arch[1] = raddr0_i;
    assign arch[2] = raddr1_i;

    win_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .save_i   (save_i),
        .restore_i(restore_i),
        .cwp_o    (cwp),
        .ovf_o    (ovf_o),
        .unf_o    (unf_o)
    );

    for (genvar g = 0; g < 3; g++) begin : g_map
        win_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
            .arch_i(arch[g]),
            .cwp_i (cwp),
            .phys_o(phys[g])
        );
    end

    win_bank #(.XLEN(XLEN), .PHYS(PHYS), .PW(PW)) u_bank (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .we_i  (we_i),
        .wa_i  (phys[0]),
        .wd_i  (wdata_i),
        .ra0_i (phys[1]),
        .ra1_i (phys[2]),
        .rd0_o (rdata0_o),
        .rd1_o (rdata1_o)
    );

    assign cwp_o = cwp;

    // R2: register 0 is zero at both ports
    a_r2_zero_port0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raddr0_i == '0) |-> (rdata0_o == '0));
    a_r2_zero_port1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raddr1_i == '0) |-> (rdata1_o == '0));
    // R9: same-register read during a write shows the new data
    a_r9_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && waddr_i != '0 && waddr_i == raddr0_i) |-> (rdata0_o == wdata_i));
    // R6/R7: the two refusal flags never rise together
    a_r6_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ovf_o && unf_o));
endmodule

// File: tb/win_regfile_tb.sv
`timescale 1ns/1ps
module win_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW         = 4;
    localparam int XL         = 32;

    typedef struct packed {
        logic [1:0]  op;      // 0 idle, 1 save, 2 restore, 3 both
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [31:0] exp_rd;  // read result before the edge
        logic [1:0]  exp_cwp; // pointer after the edge
    } vec_t;

    // Covers R1 R2 R3 R4 R5 R8 R9 R10
    localparam vec_t VECS [15] = '{
        '{2'd0, 1'b1, 5'd8,  32'h11, 5'd8,  32'h11, 2'd0}, // R9 bypass
        '{2'd0, 1'b1, 5'd16, 32'h22, 5'd8,  32'h11, 2'd0}, // R10 stored
        '{2'd1, 1'b0, 5'd0,  32'h0,  5'd16, 32'h22, 2'd3}, // R5 save wraps 0->3
        '{2'd0, 1'b0, 5'd0,  32'h0,  5'd24, 32'h11, 2'd3}, // R3 ins = caller outs
        '{2'd0, 1'b0, 5'd0,  32'h0,  5'd16, 32'h0,  2'd3}, // R4 local private
        '{2'd0, 1'b1, 5'd24, 32'h33, 5'd0,  32'h0,  2'd3}, // R3 return value
        '{2'd2, 1'b0, 5'd0,  32'h0,  5'd8,  32'h0,  2'd0}, // R5 restore wraps 3->0
        '{2'd0, 1'b0, 5'd0,  32'h0,  5'd8,  32'h33, 2'd0}, // R3 caller outs
        '{2'd0, 1'b0, 5'd0,  32'h0,  5'd16, 32'h22, 2'd0}, // R4 caller local back
        '{2'd0, 1'b1, 5'd5,  32'h55, 5'd5,  32'h55, 2'd0}, // R1 global write
        '{2'd1, 1'b0, 5'd0,  32'h0,  5'd0,  32'h0,  2'd3}, // R5 save
        '{2'd0, 1'b0, 5'd0,  32'h0,  5'd5,  32'h55, 2'd3}, // R1 global shared
        '{2'd0, 1'b1, 5'd0,  32'hFF, 5'd0,  32'h0,  2'd3}, // R2 write dropped
        '{2'd3, 1'b0, 5'd0,  32'h0,  5'd0,  32'h0,  2'd3}, // R8 both cancel
        '{2'd2, 1'b0, 5'd0,  32'h0,  5'd0,  32'h0,  2'd0}  // R5 restore
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          save = 1'b0, restore = 1'b0, we = 1'b0;
    logic [4:0]    waddr = '0, raddr0 = '0, raddr1 = '0;
    logic [XL-1:0] wdata = '0;
    logic [XL-1:0] rdata0, rdata1;
    logic [1:0]    cwp;
    logic          ovf, unf;
    int            checks = 0;
    int            fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    win_regfile #(.XLEN(XL), .NWIN(NW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .save_i(save), .restore_i(restore),
        .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
        .raddr0_i(raddr0), .raddr1_i(raddr1),
        .rdata0_o(rdata0), .rdata1_o(rdata1),
        .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic w, input logic [4:0] wa,
                         input logic [31:0] wd, input logic [4:0] ra);
        @(negedge clk);
        save    = op[0];
        restore = op[1];
        we      = w;
        waddr   = wa;
        wdata   = wd;
        raddr0  = ra;
        raddr1  = ra;
        #1;
    endtask

    task automatic settle;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        drive(2'd0, 1'b0, 5'd0, 32'h0, 5'd8);
        chk("R11 r8 after reset", rdata0, 32'h0);
        drive(2'd0, 1'b0, 5'd0, 32'h0, 5'd31);
        chk("R11 r31 after reset", rdata1, 32'h0);
        chk("R5 reset pointer", {30'd0, cwp}, 32'd0);
        chk("R7 reset flags", {30'd0, ovf, unf}, 32'd0);

        for (int i = 0; i < 15; i++) begin
            drive(VECS[i].op, VECS[i].we, VECS[i].wa, VECS[i].wd, VECS[i].ra);
            chk($sformatf("table %0d rd0 (R1 R2 R3 R4 R9)", i), rdata0, VECS[i].exp_rd);
            chk($sformatf("table %0d rd1 (R1 R2 R3 R4 R9)", i), rdata1, VECS[i].exp_rd);
            chk($sformatf("table %0d flags (R8)", i), {30'd0, ovf, unf}, 32'd0);
            settle();
            chk($sformatf("table %0d pointer (R5 R10)", i), {30'd0, cwp}, {30'd0, VECS[i].exp_cwp});
        end

        // R7 underflow: one live window, cwp 0
        drive(2'd2, 1'b0, 5'd0, 32'h0, 5'd0);
        chk("R7 unf on restore at base", {31'd0, unf}, 32'd1);
        chk("R7 no ovf", {31'd0, ovf}, 32'd0);
        settle();
        chk("R7 pointer held", {30'd0, cwp}, 32'd0);

        drive(2'd1, 1'b0, 5'd0, 32'h0, 5'd0);
        settle();
        chk("R5 save to 3", {30'd0, cwp}, 32'd3);
        // R10 write during save goes to window 3 local
        drive(2'd1, 1'b1, 5'd16, 32'h77, 5'd0);
        chk("R6 no ovf at 2 live", {31'd0, ovf}, 32'd0);
        settle();
        chk("R5 save to 2", {30'd0, cwp}, 32'd2);
        drive(2'd0, 1'b0, 5'd0, 32'h0, 5'd16);
        chk("R10 write not in new window", rdata0, 32'h0);

        // R6 overflow: 3 live of 4
        drive(2'd1, 1'b0, 5'd0, 32'h0, 5'd0);
        chk("R6 ovf on full save", {31'd0, ovf}, 32'd1);
        chk("R6 no unf", {31'd0, unf}, 32'd0);
        settle();
        chk("R6 pointer held", {30'd0, cwp}, 32'd2);

        drive(2'd2, 1'b0, 5'd0, 32'h0, 5'd0);
        settle();
        chk("R5 restore to 3", {30'd0, cwp}, 32'd3);
        drive(2'd0, 1'b0, 5'd0, 32'h0, 5'd16);
        chk("R10 write landed in old window", rdata0, 32'h77);
        drive(2'd2, 1'b0, 5'd0, 32'h0, 5'd0);
        settle();
        chk("R5 restore to 0", {30'd0, cwp}, 32'd0);
        drive(2'd2, 1'b0, 5'd0, 32'h0, 5'd0);
        chk("R7 unf again", {31'd0, unf}, 32'd1);
        settle();
        chk("R7 pointer held again", {30'd0, cwp}, 32'd0);

        drive(2'd0, 1'b0, 5'd0, 32'h0, 5'd0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule